// File: doc/BRIEF.md
# Per-Carrier Variable-Order QAM Mapper

This block turns a serial stream of transmit bits into one complex constellation point per subcarrier of a multicarrier symbol. A small loading table holds a modulation order for every carrier. Walking the carriers from index 0 upward, the block takes exactly as many bits as the current carrier's entry calls for, forms the I and Q values, and presents them with the carrier index and an end-of-symbol flag to the following reordering/transform stage.

Orders are none, BPSK, QPSK, 16-QAM and 64-QAM. A carrier set to none takes no bits and yields a zero point. The levels on each axis are Gray coded and scaled per order so that every order has the same mean symbol energy. The table is filled from the result of a bit-loading calculation; writes land only while the block sits between symbols, so a symbol is always mapped with one consistent table.

The control is a three-state machine. IDLE waits between symbols; the transition IDLE to GATHER is taken when an input bit is offered. GATHER shifts in the current carrier's bits one per accepted handshake; GATHER to EMIT is taken when the last needed bit is accepted, or at once when the carrier needs no bits. EMIT holds the point until the consumer accepts it; EMIT to GATHER moves to the next carrier, and EMIT to IDLE is taken after the last carrier is accepted.

Top module: `carrier_qam_mapper`

## Requirements
- R1: After reset `sym_valid` and `bit_ready` are low, the carrier index is 0, and every table entry holds QPSK (code 2).
- R2: Table code 0, 1, 2, 3, 4 selects none, BPSK, QPSK, 16-QAM, 64-QAM, and the carrier consumes exactly 0, 1, 2, 4, 6 input bits respectively.
- R3: A carrier with code 0 consumes no bits and is emitted with `sym_i` = `sym_q` = 0.
- R4: BPSK uses one bit on I only: bit 0 gives I = -A, bit 1 gives I = +A, Q = 0, where A = 2^(OUT_W-2).
- R5: Bits arrive MSB first; the first half of a carrier's bits forms the I field and the second half the Q field. Per axis, a 1-bit field maps 0/1 to -1/+1; a 2-bit field maps 00,01,11,10 to -3,-1,+1,+3; a 3-bit field maps 000,001,011,010,110,111,101,100 to -7,-5,-3,-1,+1,+3,+5,+7.
- R6: The level is multiplied by a per-order unit: A for BPSK, round(A/sqrt(2)) for QPSK, round(A/sqrt(10)) for 16-QAM, round(A/sqrt(42)) for 64-QAM.
- R7: Carriers are emitted in index order 0 to NUM_CARRIERS-1 on `sym_idx`; `sym_last` is high only with the final carrier, after which the next symbol starts again at index 0.
- R8: While `sym_valid` is high and `sym_ready` is low, `sym_i`, `sym_q` and `sym_idx` stay unchanged and `bit_ready` is low.
- R9: The block advances only on tokens: with no input bit offered it stays in IDLE with `sym_valid` low, and gaps in `bit_valid` while gathering only delay the result.
- R10: Table writes issued while a symbol is in progress (from the first offered bit until the last carrier is accepted) are discarded.
- R11: A table write carrying a code of 5, 6 or 7 is discarded and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loading-table write strobe |
| cfg_addr | input | CIDX_W | Carrier whose entry is written |
| cfg_code | input | 3 | Modulation code to write (0..4) |
| bit_valid | input | 1 | An input bit is offered |
| bit_data | input | 1 | The offered bit |
| bit_ready | output | 1 | The block takes the offered bit this cycle |
| sym_valid | output | 1 | A carrier point is presented |
| sym_ready | input | 1 | The consumer takes the point this cycle |
| sym_i | output | OUT_W | In-phase value, two's complement |
| sym_q | output | OUT_W | Quadrature value, two's complement |
| sym_idx | output | CIDX_W | Carrier index of the presented point |
| sym_last | output | 1 | Presented point is the symbol's last carrier |

## Verification
The bench builds the block with NUM_CARRIERS = 8 and OUT_W = 12, so A = 1024 and the units are 1024, 724, 324 and 158. Eight carriers make a symbol short enough that eight 64-QAM symbols cover all 64 six-bit patterns and two 16-QAM symbols cover all 16, while the wrap from the last carrier back to IDLE is crossed in every scenario. A mixed table with zero-loaded carriers at the first and an inner position exercises the immediate GATHER to EMIT path, and mid-symbol writes aim at the last carrier so a wrongly accepted write would change a carrier still to come.

// File: rtl/qmap_pkg.sv
package qmap_pkg;

    // Modulation code stored per carrier
    typedef enum logic [2:0] {
        LD_NONE  = 3'd0,
        LD_BPSK  = 3'd1,
        LD_QPSK  = 3'd2,
        LD_QAM16 = 3'd3,
        LD_QAM64 = 3'd4
    } load_code_e;

    // Mapper control states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_EMIT
    } map_state_e;

    localparam int MAX_BITS = 6;

    // Bits consumed by one carrier for a given code
    function automatic logic [2:0] bits_for(logic [2:0] code);
        case (code)
            3'd1:    return 3'd1;
            3'd2:    return 3'd2;
            3'd3:    return 3'd4;
            3'd4:    return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    // Integer square root (floor), used for elaboration-time scale units
    function automatic longint isqrt(longint x);
        longint r;
        longint t;
        r = 0;
        for (int b = 31; b >= 0; b--) begin
            t = r | (longint'(1) << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

endpackage

// File: rtl/qmap_load_table.sv
module qmap_load_table
    import qmap_pkg::*;
#(
    parameter int NC = 48,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2:0]    wr_code,
    input  logic [AW-1:0] rd_addr,
    output logic [2:0]    rd_code
);

    logic [NC-1:0][2:0] ent;
    logic               wr_legal;

    assign wr_legal = (wr_code <= 3'd4) && (int'(wr_addr) < NC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NC; k++) ent[k] <= 3'(LD_QPSK);
        end else if (wr_allow && wr_en && wr_legal) begin
            ent[wr_addr] <= wr_code;
        end
    end

    always_comb begin
        rd_code = 3'(LD_NONE);
        if (int'(rd_addr) < NC) rd_code = ent[rd_addr];
    end

    // Table contents frozen while a symbol is in flight
    assert_table_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(ent));

    // Out-of-range codes never land
    assert_bad_code_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code > 3'd4) |=> $stable(ent));

endmodule

// File: rtl/qmap_axis.sv
module qmap_axis
    import qmap_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  logic                    en,
    input  logic [2:0]              code,
    input  logic [2:0]              gbits,
    output logic signed [OUT_W-1:0] val
);

    localparam longint AMP     = longint'(1) << (OUT_W - 2);
    localparam longint K_BPSK  = AMP;
    localparam longint K_QPSK  = (isqrt(4 * AMP * AMP / 2) + 1) / 2;
    localparam longint K_QAM16 = (isqrt(4 * AMP * AMP / 10) + 1) / 2;
    localparam longint K_QAM64 = (isqrt(4 * AMP * AMP / 42) + 1) / 2;
    localparam int     PW      = OUT_W + 5;

    logic [2:0]              bin;
    logic signed [4:0]       span;
    logic signed [4:0]       lvl;
    logic signed [OUT_W-1:0] unit;
    logic signed [PW-1:0]    prod;

    // Gray field to binary, then binary to odd level
    always_comb begin
        bin  = 3'd0;
        span = 5'sd0;
        unit = '0;
        case (code)
            LD_BPSK: begin
                bin  = {2'b00, gbits[0]};
                span = 5'sd1;
                unit = OUT_W'(K_BPSK);
            end
            LD_QPSK: begin
                bin  = {2'b00, gbits[0]};
                span = 5'sd1;
                unit = OUT_W'(K_QPSK);
            end
            LD_QAM16: begin
                bin  = {1'b0, gbits[1], gbits[1] ^ gbits[0]};
                span = 5'sd3;
                unit = OUT_W'(K_QAM16);
            end
            LD_QAM64: begin
                bin  = {gbits[2], gbits[2] ^ gbits[1], gbits[2] ^ gbits[1] ^ gbits[0]};
                span = 5'sd7;
                unit = OUT_W'(K_QAM64);
            end
            default: begin
                bin  = 3'd0;
                span = 5'sd0;
                unit = '0;
            end
        endcase
        lvl  = $signed({1'b0, bin, 1'b0}) - span;
        prod = PW'(lvl) * PW'(unit);
        val  = en ? prod[OUT_W-1:0] : '0;

        if (en && code != 3'(LD_NONE) && code <= 3'd4) begin
            assert_level_odd_R5: assert (lvl[0] == 1'b1);
            assert_level_span_R5: assert (lvl <= span && lvl >= -span);
        end
    end

endmodule

// File: rtl/carrier_qam_mapper.sv
module carrier_qam_mapper
    import qmap_pkg::*;
#(
    parameter int NUM_CARRIERS = 48,
    parameter int OUT_W        = 12,
    localparam int CIDX_W      = $clog2(NUM_CARRIERS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CIDX_W-1:0]       cfg_addr,
    input  logic [2:0]              cfg_code,
    input  logic                    bit_valid,
    input  logic                    bit_data,
    output logic                    bit_ready,
    output logic                    sym_valid,
    input  logic                    sym_ready,
    output logic signed [OUT_W-1:0] sym_i,
    output logic signed [OUT_W-1:0] sym_q,
    output logic [CIDX_W-1:0]       sym_idx,
    output logic                    sym_last
);

    localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CARRIERS - 1);

    map_state_e              state;
    map_state_e              state_nxt;
    logic [CIDX_W-1:0]       idx;
    logic [2:0]              cnt;
    logic [MAX_BITS-1:0]     shreg;
    logic [2:0]              cur_code;
    logic [2:0]              need;
    logic                    at_last;
    logic                    take_bit;
    logic [2:0]              ax_bits [2];
    logic                    ax_en   [2];
    logic signed [OUT_W-1:0] ax_val  [2];

    // Loading table, writable only between symbols
    qmap_load_table #(
        .NC (NUM_CARRIERS),
        .AW (CIDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (state == ST_IDLE),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_code  (cfg_code),
        .rd_addr  (idx),
        .rd_code  (cur_code)
    );

    assign need     = bits_for(cur_code);
    assign at_last  = (idx == LAST_IDX);
    assign take_bit = (state == ST_GATHER) && (need != 3'd0) && bit_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (bit_valid) state_nxt = ST_GATHER;
            end
            ST_GATHER: begin
                if (need == 3'd0)                          state_nxt = ST_EMIT;
                else if (bit_valid && (cnt + 3'd1 == need)) state_nxt = ST_EMIT;
            end
            ST_EMIT: begin
                if (sym_ready) state_nxt = at_last ? ST_IDLE : ST_GATHER;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Carrier index, bit count and bit shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            cnt   <= 3'd0;
            shreg <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= 3'd0;
                end
                ST_GATHER: begin
                    if (take_bit) begin
                        shreg <= {shreg[MAX_BITS-2:0], bit_data};
                        cnt   <= cnt + 3'd1;
                    end
                end
                ST_EMIT: begin
                    if (sym_ready) begin
                        cnt <= 3'd0;
                        idx <= at_last ? '0 : idx + 1'b1;
                    end
                end
                default: cnt <= 3'd0;
            endcase
        end
    end

    // Split gathered bits into I and Q fields (first half is I)
    always_comb begin
        ax_bits[0] = 3'd0;
        ax_bits[1] = 3'd0;
        ax_en[0]   = 1'b0;
        ax_en[1]   = 1'b0;
        case (cur_code)
            LD_BPSK: begin
                ax_bits[0] = {2'b00, shreg[0]};
                ax_en[0]   = 1'b1;
            end
            LD_QPSK: begin
                ax_bits[0] = {2'b00, shreg[1]};
                ax_bits[1] = {2'b00, shreg[0]};
                ax_en[0]   = 1'b1;
                ax_en[1]   = 1'b1;
            end
            LD_QAM16: begin
                ax_bits[0] = {1'b0, shreg[3:2]};
                ax_bits[1] = {1'b0, shreg[1:0]};
                ax_en[0]   = 1'b1;
                ax_en[1]   = 1'b1;
            end
            LD_QAM64: begin
                ax_bits[0] = shreg[5:3];
                ax_bits[1] = shreg[2:0];
                ax_en[0]   = 1'b1;
                ax_en[1]   = 1'b1;
            end
            default: begin
                ax_en[0] = 1'b0;
                ax_en[1] = 1'b0;
            end
        endcase
    end

    // One level/scale unit per axis
    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        qmap_axis #(
            .OUT_W (OUT_W)
        ) u_axis (
            .en    (ax_en[ax]),
            .code  (cur_code),
            .gbits (ax_bits[ax]),
            .val   (ax_val[ax])
        );
    end

    // Outputs
    always_comb begin
        sym_valid = (state == ST_EMIT);
        sym_last  = (state == ST_EMIT) && at_last;
        bit_ready = (state == ST_GATHER) && (need != 3'd0);
        sym_idx   = idx;
        sym_i     = ax_val[0];
        sym_q     = ax_val[1];
    end

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_i) && $stable(sym_q) && $stable(sym_idx)));

    assert_wait_for_token_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATHER && need != 3'd0 && !bit_valid) |=> (state == ST_GATHER && $stable(cnt) && $stable(shreg)));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATHER && need != 3'd0) |-> (cnt < need));

    assert_zero_carrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && cur_code == 3'(LD_NONE)) |-> (sym_i == '0 && sym_q == '0));

    assert_index_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && !sym_last) |=> (sym_idx == $past(sym_idx) + 1'b1));

endmodule

// File: tb/carrier_qam_mapper_tb.sv
module carrier_qam_mapper_tb;

    localparam int NC    = 8;
    localparam int OUT_W = 12;
    localparam int AW    = 3;
    localparam int AMP   = 1 << (OUT_W - 2);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [AW-1:0]           cfg_addr = '0;
    logic [2:0]              cfg_code = '0;
    logic                    bit_valid = 1'b0;
    logic                    bit_data = 1'b0;
    logic                    bit_ready;
    logic                    sym_valid;
    logic                    sym_ready = 1'b0;
    logic signed [OUT_W-1:0] sym_i;
    logic signed [OUT_W-1:0] sym_q;
    logic [AW-1:0]           sym_idx;
    logic                    sym_last;

    carrier_qam_mapper #(
        .NUM_CARRIERS (NC),
        .OUT_W        (OUT_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_code  (cfg_code),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_ready (bit_ready),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .sym_i     (sym_i),
        .sym_q     (sym_q),
        .sym_idx   (sym_idx),
        .sym_last  (sym_last)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int total = 0;
    int bad   = 0;
    int tb_tbl [NC];
    bit tb_bits [NC*6];
    int k_b, k_q, k_16, k_64;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int nbits(input int code);
        case (code)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int gray_lvl(input int m, input int g);
        if (m == 1) return g ? 1 : -1;
        if (m == 2) begin
            case (g)
                0: return -3;
                1: return -1;
                3: return 1;
                default: return 3;
            endcase
        end
        case (g)
            0: return -7;
            1: return -5;
            3: return -3;
            2: return -1;
            6: return 1;
            7: return 3;
            5: return 5;
            default: return 7;
        endcase
    endfunction

    task automatic exp_iq(input int code, input int v, output int ei, output int eq);
        ei = 0;
        eq = 0;
        case (code)
            1: ei = gray_lvl(1, v) * k_b;
            2: begin ei = gray_lvl(1, v >> 1) * k_q;  eq = gray_lvl(1, v & 1) * k_q;  end
            3: begin ei = gray_lvl(2, v >> 2) * k_16; eq = gray_lvl(2, v & 3) * k_16; end
            4: begin ei = gray_lvl(3, v >> 3) * k_64; eq = gray_lvl(3, v & 7) * k_64; end
            default: begin ei = 0; eq = 0; end
        endcase
    endtask

    task automatic write_cfg(input int a, input int code);
        cfg_we   = 1'b1;
        cfg_addr = AW'(a);
        cfg_code = 3'(code);
        @(negedge clk);
        cfg_we = 1'b0;
        if (code <= 4) tb_tbl[a] = code;
    endtask

    task automatic fill_random(input int seed);
        int s;
        s = seed;
        for (int k = 0; k < NC*6; k++) begin
            s = s ^ (s << 13);
            s = s ^ (s >>> 17);
            s = s ^ (s << 5);
            tb_bits[k] = s[7];
        end
    endtask

    // Each carrier c gets the value base+c, MSB first
    task automatic fill_count(input int base);
        int pos;
        pos = 0;
        for (int c = 0; c < NC; c++) begin
            int n;
            n = nbits(tb_tbl[c]);
            for (int b = n - 1; b >= 0; b--) begin
                tb_bits[pos] = ((base + c) >> b) & 1;
                pos++;
            end
        end
    endtask

    // Runs one full symbol. stall_mode shapes sym_ready, gap inserts bit_valid gaps.
    task automatic run_symbol(input string req, input int stall_mode, input int gap, input bit mid_write);
        int nb_tot;
        int e_i [NC];
        int e_q [NC];
        int pos;
        nb_tot = 0;
        pos    = 0;
        for (int c = 0; c < NC; c++) begin
            int n;
            int v;
            n = nbits(tb_tbl[c]);
            v = 0;
            for (int b = 0; b < n; b++) begin
                v = (v << 1) | int'(tb_bits[pos]);
                pos++;
            end
            exp_iq(tb_tbl[c], v, e_i[c], e_q[c]);
        end
        nb_tot = pos;
        fork
            begin
                for (int k = 0; k < nb_tot; k++) begin
                    if (gap > 0 && (k % 3) == 1) begin
                        bit_valid = 1'b0;
                        repeat (gap) @(negedge clk);
                    end
                    bit_valid = 1'b1;
                    bit_data  = tb_bits[k];
                    while (!bit_ready) @(negedge clk);
                    @(negedge clk);
                end
                bit_valid = 1'b0;
            end
            begin
                bit held;
                int hi, hq, hx;
                held = 1'b0;
                hi = 0; hq = 0; hx = 0;
                for (int c = 0; c < NC; c++) begin
                    bit done;
                    done = 1'b0;
                    while (!done) begin
                        @(negedge clk);
                        cfg_we = 1'b0;
                        case (stall_mode)
                            1:       sym_ready = (cyc % 3) != 0;
                            2:       sym_ready = (cyc % 4) == 3;
                            default: sym_ready = 1'b1;
                        endcase
                        if (held && sym_valid) begin
                            chk(int'(sym_i) == hi && int'(sym_q) == hq && int'(sym_idx) == hx && !bit_ready,
                                "R8", "stalled point changed", int'(sym_i), hi);
                        end
                        held = 1'b0;
                        if (sym_valid && sym_ready) begin
                            chk(int'(sym_i) == e_i[c], req, $sformatf("carrier %0d I", c), int'(sym_i), e_i[c]);
                            chk(int'(sym_q) == e_q[c], req, $sformatf("carrier %0d Q", c), int'(sym_q), e_q[c]);
                            chk(int'(sym_idx) == c && sym_last == (c == NC - 1), "R7",
                                $sformatf("index/last at carrier %0d", c), int'(sym_idx) * 2 + int'(sym_last),
                                c * 2 + int'(c == NC - 1));
                            done = 1'b1;
                            if (mid_write && c == 2) begin
                                cfg_we   = 1'b1;
                                cfg_addr = AW'(NC - 1);
                                cfg_code = 3'd4;
                            end
                        end else if (sym_valid) begin
                            held = 1'b1;
                            hi = int'(sym_i);
                            hq = int'(sym_q);
                            hx = int'(sym_idx);
                        end
                    end
                end
            end
        join
        @(negedge clk);
        cfg_we    = 1'b0;
        sym_ready = 1'b0;
    endtask

    task automatic set_mixed();
        int codes [NC];
        codes = '{0, 1, 2, 3, 4, 0, 4, 3};
        for (int c = 0; c < NC; c++) write_cfg(c, codes[c]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!sym_valid, "R1", "sym_valid after reset", int'(sym_valid), 0);
        chk(!bit_ready, "R1", "bit_ready after reset", int'(bit_ready), 0);
        chk(sym_idx == '0, "R1", "index after reset", int'(sym_idx), 0);
        fill_random(32'h1234_5678);
        run_symbol("R1", 0, 0, 1'b0);
    endtask

    task automatic t_no_token();
        bit quiet;
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (sym_valid || bit_ready) quiet = 1'b0;
        end
        chk(quiet, "R9", "activity without input token", int'(quiet), 1);
    endtask

    task automatic t_bpsk();
        for (int c = 0; c < NC; c++) write_cfg(c, 1);
        for (int k = 0; k < NC; k++) tb_bits[k] = k[0] ^ k[2];
        run_symbol("R4", 1, 0, 1'b0);
    endtask

    task automatic t_mixed();
        set_mixed();
        fill_random(32'h0BAD_F00D);
        run_symbol("R2 R3 R6", 0, 0, 1'b0);
        fill_random(32'h7777_1111);
        run_symbol("R2 R3 R6", 1, 1, 1'b0);
    endtask

    task automatic t_qam64_all();
        for (int c = 0; c < NC; c++) write_cfg(c, 4);
        for (int s = 0; s < 8; s++) begin
            fill_count(s * 8);
            run_symbol("R5", 0, 0, 1'b0);
        end
    endtask

    task automatic t_qam16_all();
        for (int c = 0; c < NC; c++) write_cfg(c, 3);
        for (int s = 0; s < 2; s++) begin
            fill_count(s * 8);
            run_symbol("R5", 0, 0, 1'b0);
        end
    endtask

    task automatic t_backpressure();
        set_mixed();
        fill_random(32'h5A5A_A5A5);
        run_symbol("R8 R9", 2, 2, 1'b0);
    endtask

    task automatic t_mid_write();
        set_mixed();
        fill_random(32'h2468_ACE0);
        run_symbol("R10", 0, 0, 1'b1);
        fill_random(32'h1357_9BDF);
        run_symbol("R10", 0, 0, 1'b0);
    endtask

    task automatic t_bad_code();
        set_mixed();
        write_cfg(1, 5);
        write_cfg(2, 7);
        write_cfg(4, 6);
        fill_random(32'h0F0F_3C3C);
        run_symbol("R11", 0, 0, 1'b0);
    endtask

    initial begin
        k_b  = AMP;
        k_q  = $rtoi(real'(AMP) / $sqrt(2.0) + 0.5);
        k_16 = $rtoi(real'(AMP) / $sqrt(10.0) + 0.5);
        k_64 = $rtoi(real'(AMP) / $sqrt(42.0) + 0.5);
        for (int c = 0; c < NC; c++) tb_tbl[c] = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        t_reset();
        t_no_token();
        t_bpsk();
        t_mixed();
        t_qam64_all();
        t_qam16_all();
        t_backpressure();
        t_mid_write();
        t_bad_code();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule